// File: doc/BRIEF.md
# Two-Bank Serial EEPROM Write Sequencer

This block is an I2C master that only writes. It stores bytes into a 64 KB serial EEPROM that answers at two device addresses, one for each 32 KB half. A 16-bit pointer selects the target location. Bit 15 of the pointer picks which half, and so which device address, the control byte carries. The pointer moves forward by one after every byte the memory acknowledges. A separate port can shift it by an 8-bit amount up or down.

A request in single mode produces a complete framed write. The block then holds busy for the memory's internal write time. A request in page mode opens a transaction and sends the addressing once. The block then parks with SCL held low, ready for more data bytes. Each later request adds one data byte only. A page-end pulse closes the transaction with a stop and the same write-time wait. SCL and SDA are driven as open-drain pull-down enables. The block samples the wired SDA line during the acknowledge clock.

Top module: `i2c_ee_writer`

## Requirements
- R1: After reset both pull-down enables are low, busy_o and nack_o are low and addr_o is 0x0000. In idle both enables stay low.
- R2: Inside a byte, SDA changes only while SCL is held low. Bits go out MSB first, and the 9th clock samples the acknowledge (SDA low means ACK). A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high.
- R3: The control byte is 0xA6 (1010_0110) when pointer bit 15 is 0 and 0xAE (1010_1110) when it is 1. Bit 3 carries bit 15 and bit 0 = 0 marks a write.
- R4: A single-mode request (page_mode_i = 0) sends, in order: start, control byte, pointer high byte, pointer low byte, data byte, stop.
- R5: After the stop of a single write, busy_o stays high for WAIT_US microseconds of clk_i. While busy_o is high, write requests and pointer adjusts are ignored.
- R6: A page-mode request sends start, control, both pointer bytes and data, then leaves SCL held low with busy_o low. Each further request sends only its data byte, whatever page_mode_i is.
- R7: page_end_i during an open page sends a stop and then the R5 wait. page_end_i while idle has no effect.
- R8: The pointer increments by one after each acknowledged data byte, with carry from the low byte into the high byte and a wrap from 0xFFFF to 0x0000.
- R9: A NACK on any byte gives a one-cycle nack_o pulse, a stop and a return to idle with no write wait. The pointer is left unchanged.
- R10: adj_en_i while idle adds adj_amt_i to the pointer, or subtracts it when adj_sub_i = 1, modulo 2^16.
- R11: SCL stays high for half of a period of CLK_HZ/SCL_HZ clk_i cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | One-cycle write request |
| page_mode_i | input | 1 | 1 opens a page transaction on an idle request |
| wr_data_i | input | 8 | Data byte for the request |
| page_end_i | input | 1 | Closes an open page transaction |
| adj_en_i | input | 1 | Applies a pointer adjust |
| adj_sub_i | input | 1 | 1 subtracts, 0 adds |
| adj_amt_i | input | 8 | Adjust amount |
| sda_i | input | 1 | Wired SDA line level |
| scl_oe_o | output | 1 | Pulls SCL low when 1 |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| busy_o | output | 1 | Sequencer is framing or waiting |
| nack_o | output | 1 | One-cycle pulse on a missing acknowledge |
| addr_o | output | 16 | Current memory pointer |

## Verification
A wrong sequencer state shows at the bus within one byte time. A byte can be missing, repeated or out of order. A stop can be missing from a single write, or a stray stop can appear in a page. A wrong pointer or bank bit shows in the very next control and address bytes, and it also shows at addr_o one cycle after the data byte's acknowledge. A wrong wait counter shows as busy_o falling too early or too late relative to the stop, by more than a few cycles.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {CMD_START, CMD_BYTE, CMD_STOP} cmd_e;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CTRL, ST_AHI, ST_ALO, ST_DATA, ST_STOP, ST_WAIT, ST_OPEN
  } state_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // bank bit lands in bit 3, bit 0 = 0 selects write
  function automatic logic [7:0] ctrl_byte(input logic bank);
    return {DEV_TYPE, bank, 3'b110};
  endfunction
endpackage

// File: rtl/i2cw_addr_ptr.sv
module i2cw_addr_ptr #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          adj_en_i,
  input  logic          adj_sub_i,
  input  logic [SW-1:0] adj_amt_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] amt_ext;
  assign amt_ext = {{(AW-SW){1'b0}}, adj_amt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else if (inc_i) addr_o <= addr_o + AW'(1);
    else if (adj_en_i) addr_o <= adj_sub_i ? addr_o - amt_ext : addr_o + amt_ext;
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> addr_o == $past(addr_o) + AW'(1)); // R8
  AST_PTR_ADJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_en_i && !inc_i) |=> addr_o == ($past(adj_sub_i) ? $past(addr_o) - $past(amt_ext)
                                                         : $past(addr_o) + $past(amt_ext))); // R10
endmodule

// File: rtl/i2cw_bit_engine.sv
module i2cw_bit_engine
  import i2cw_pkg::*;
#(
  parameter int QTR = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  cmd_e       cmd_i,
  input  logic [7:0] byte_i,
  input  logic       sda_i,
  output logic       done_o,
  output logic       nack_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic          active_q;
  cmd_e          cmd_q;
  logic [1:0]    ph_q;
  logic [3:0]    bit_q;
  logic [8:0]    sh_q;
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = active_q && (cnt_q == CW'(QTR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cmd_q    <= CMD_START;
      ph_q     <= '0;
      bit_q    <= '0;
      sh_q     <= '1;
      cnt_q    <= '0;
      done_o   <= 1'b0;
      nack_o   <= 1'b0;
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        cmd_q    <= cmd_i;
        sh_q     <= {byte_i, 1'b1};
        ph_q     <= '0;
        bit_q    <= '0;
        cnt_q    <= '0;
      end else if (active_q) begin
        cnt_q <= tick ? '0 : cnt_q + CW'(1);
        if (tick) begin
          unique case (cmd_q)
            CMD_START: begin
              if (ph_q == 2'd0) begin scl_oe_o <= 1'b0; sda_oe_o <= 1'b0; end
              if (ph_q == 2'd1) sda_oe_o <= 1'b1;
              if (ph_q == 2'd2) scl_oe_o <= 1'b1;
            end
            CMD_STOP: begin
              if (ph_q == 2'd0) sda_oe_o <= 1'b1;
              if (ph_q == 2'd1) scl_oe_o <= 1'b0;
              if (ph_q == 2'd2) sda_oe_o <= 1'b0;
            end
            default: begin
              if (ph_q == 2'd0) sda_oe_o <= ~sh_q[8];
              if (ph_q == 2'd1) scl_oe_o <= 1'b0;
              if (ph_q == 2'd2 && bit_q == 4'd8) nack_o <= sda_i;
              if (ph_q == 2'd3) begin
                scl_oe_o <= 1'b1;
                sh_q     <= {sh_q[7:0], 1'b1};
              end
            end
          endcase
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd3) begin
            if (cmd_q != CMD_BYTE || bit_q == 4'd8) begin
              active_q <= 1'b0;
              done_o   <= 1'b1;
            end else begin
              bit_q <= bit_q + 4'd1;
            end
          end
        end
      end
    end
  end

  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cmd_q == CMD_BYTE && !$stable(sda_oe_o)) |-> ($past(scl_oe_o) && scl_oe_o)); // R2
endmodule

// File: rtl/i2c_ee_writer.sv
module i2c_ee_writer
  import i2cw_pkg::*;
#(
  parameter int CLK_HZ  = 16_000_000,
  parameter int SCL_HZ  = 400_000,
  parameter int WAIT_US = 5000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_req_i,
  input  logic        page_mode_i,
  input  logic [7:0]  wr_data_i,
  input  logic        page_end_i,
  input  logic        adj_en_i,
  input  logic        adj_sub_i,
  input  logic [7:0]  adj_amt_i,
  input  logic        sda_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  output logic        busy_o,
  output logic        nack_o,
  output logic [15:0] addr_o
);
  localparam int AW       = 16;
  localparam int QTR      = (CLK_HZ / (4 * SCL_HZ) > 0) ? CLK_HZ / (4 * SCL_HZ) : 1;
  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int WW       = $clog2(WAIT_CYC + 1);

  state_e        state_q, state_n;
  logic          go_q, abort_q, page_q;
  logic [7:0]    data_q;
  logic [WW-1:0] wait_q;
  cmd_e          eng_cmd;
  logic [7:0]    eng_byte;
  logic          eng_done, eng_nack;
  logic          byte_st, abort_set, ptr_inc, ptr_adj;
  logic [AW-1:0] addr_w;

  function automatic logic issues_cmd(input state_e s);
    return s inside {ST_START, ST_CTRL, ST_AHI, ST_ALO, ST_DATA, ST_STOP};
  endfunction

  assign byte_st   = state_q inside {ST_CTRL, ST_AHI, ST_ALO, ST_DATA};
  assign abort_set = byte_st && eng_done && eng_nack;
  assign ptr_inc   = (state_q == ST_DATA) && eng_done && !eng_nack;
  assign ptr_adj   = (state_q == ST_IDLE) && adj_en_i;
  assign busy_o    = !(state_q inside {ST_IDLE, ST_OPEN});
  assign addr_o    = addr_w;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (wr_req_i) state_n = ST_START;
      ST_START: if (eng_done) state_n = ST_CTRL;
      ST_CTRL:  if (eng_done) state_n = eng_nack ? ST_STOP : ST_AHI;
      ST_AHI:   if (eng_done) state_n = eng_nack ? ST_STOP : ST_ALO;
      ST_ALO:   if (eng_done) state_n = eng_nack ? ST_STOP : ST_DATA;
      ST_DATA:  if (eng_done) state_n = (eng_nack || !page_q) ? ST_STOP : ST_OPEN;
      ST_OPEN:  if (wr_req_i) state_n = ST_DATA;
                else if (page_end_i) state_n = ST_STOP;
      ST_STOP:  if (eng_done) state_n = abort_q ? ST_IDLE : ST_WAIT;
      ST_WAIT:  if (wait_q == WW'(WAIT_CYC - 1)) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_START: eng_cmd = CMD_START;
      ST_STOP:  eng_cmd = CMD_STOP;
      default:  eng_cmd = CMD_BYTE;
    endcase
    unique case (state_q)
      ST_CTRL: eng_byte = ctrl_byte(addr_w[AW-1]);
      ST_AHI:  eng_byte = addr_w[15:8];
      ST_ALO:  eng_byte = addr_w[7:0];
      default: eng_byte = data_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      abort_q <= 1'b0;
      page_q  <= 1'b0;
      data_q  <= '0;
      wait_q  <= '0;
      nack_o  <= 1'b0;
    end else begin
      state_q <= state_n;
      go_q    <= (state_n != state_q) && issues_cmd(state_n);
      nack_o  <= abort_set;
      if (abort_set) abort_q <= 1'b1;
      else if (state_q == ST_IDLE) abort_q <= 1'b0;
      if (wr_req_i && state_q inside {ST_IDLE, ST_OPEN}) data_q <= wr_data_i;
      if (wr_req_i && state_q == ST_IDLE) page_q <= page_mode_i;
      wait_q <= (state_q == ST_WAIT) ? wait_q + WW'(1) : '0;
    end
  end

  i2cw_bit_engine #(.QTR(QTR)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go_q),
    .cmd_i    (eng_cmd),
    .byte_i   (eng_byte),
    .sda_i    (sda_i),
    .done_o   (eng_done),
    .nack_o   (eng_nack),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
  );

  i2cw_addr_ptr #(.AW(AW), .SW(8)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (ptr_inc),
    .adj_en_i  (ptr_adj),
    .adj_sub_i (adj_sub_i),
    .adj_amt_i (adj_amt_i),
    .addr_o    (addr_w)
  );

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!scl_oe_o && !sda_oe_o)); // R1
  AST_OPEN_HOLDS_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN) |-> (scl_oe_o && !busy_o)); // R6
  AST_NACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |=> !nack_o); // R9
  AST_NACK_PTR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> addr_w == $past(addr_w)); // R9
  AST_WAIT_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_STOP && !$past(abort_q) && $past(eng_done)) |-> busy_o); // R5
endmodule

// File: tb/i2c_ee_writer_tb.sv
module i2c_ee_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 4_000_000;
  localparam int SCL_HZ     = 500_000;
  localparam int WAIT_US    = 20;
  localparam int QTR        = CLK_HZ / (4 * SCL_HZ);
  localparam int WAIT_CYC   = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int EV_START   = 256;
  localparam int EV_STOP    = 512;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_req = 1'b0, page_mode = 1'b0, page_end = 1'b0;
  logic adj_en = 1'b0, adj_sub = 1'b0;
  logic [7:0] wr_data = '0, adj_amt = '0;
  logic scl_oe, sda_oe, busy, nack;
  logic [15:0] addr;

  logic slv_pull = 1'b0, nack_en = 1'b0;
  wire  scl_w = ~scl_oe;
  wire  sda_w = ~(sda_oe | slv_pull);

  int   n_tests = 0, n_fail = 0, err_cnt = 0;
  int   ev [0:127];
  int   ev_n = 0;
  int   bcnt = 0;
  logic [7:0] sh = '0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  time  hi_t = 0, hi_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ee_writer #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .WAIT_US(WAIT_US)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_req_i(wr_req), .page_mode_i(page_mode),
    .wr_data_i(wr_data), .page_end_i(page_end), .adj_en_i(adj_en), .adj_sub_i(adj_sub),
    .adj_amt_i(adj_amt), .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .busy_o(busy), .nack_o(nack), .addr_o(addr)
  );

  // bus monitor and acknowledging memory model
  always @(scl_w or sda_w) begin
    if (scl_w !== scl_p) begin
      if (scl_w === 1'b1) begin
        hi_t = $time;
        if (bcnt < 8) sh = {sh[6:0], sda_w};
        bcnt++;
        if (bcnt == 8 && ev_n < 128) begin ev[ev_n] = int'(sh); ev_n++; end
      end else begin
        hi_len = $time - hi_t;
        if (bcnt == 8) slv_pull = !nack_en;
        else if (bcnt == 9) begin slv_pull = 1'b0; bcnt = 0; end
      end
    end else if (sda_w !== sda_p && scl_w === 1'b1 && ev_n < 128) begin
      ev[ev_n] = (sda_w === 1'b0) ? EV_START : EV_STOP;
      ev_n++;
      bcnt = 0;
    end
    scl_p = scl_w;
    sda_p = sda_w;
  end

  always @(negedge clk) if (nack === 1'b1) err_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(input logic [7:0] d, input logic pm);
    @(negedge clk); wr_req = 1'b1; wr_data = d; page_mode = pm;
    @(negedge clk); wr_req = 1'b0; page_mode = 1'b0;
  endtask

  task automatic adj(input logic sub, input logic [7:0] amt);
    @(negedge clk); adj_en = 1'b1; adj_sub = sub; adj_amt = amt;
    @(negedge clk); adj_en = 1'b0;
  endtask

  task automatic wait_idle(input int max, output int used);
    used = 0;
    while (busy === 1'b1 && used < max) begin @(negedge clk); used++; end
  endtask

  task automatic wait_ev(input int n);
    int k = 0;
    while (ev_n < n && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset;
    chk("R1 scl_oe after reset", int'(scl_oe), 0);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 nack after reset", int'(nack), 0);
    chk("R1 addr after reset", int'(addr), 0);
  endtask

  task automatic t_adjust;
    adj(1'b0, 8'hFF); chk("R10 add ff", int'(addr), 16'h00FF);
    adj(1'b0, 8'h01); chk("R10 add carry", int'(addr), 16'h0100);
    adj(1'b1, 8'h02); chk("R10 sub borrow", int'(addr), 16'h00FE);
    adj(1'b1, 8'hFF); chk("R10 sub wrap", int'(addr), 16'hFFFF);
    adj(1'b0, 8'h07); chk("R10 add wrap", int'(addr), 16'h0006);
  endtask

  task automatic t_single;
    int b = ev_n;
    int used;
    req(8'h5A, 1'b0);
    wait_ev(b + 6);
    chk("R4 start", ev[b], EV_START);
    chk("R3 ctrl bank0", ev[b+1], 8'hA6);
    chk("R4 addr hi", ev[b+2], 8'h00);
    chk("R4 addr lo", ev[b+3], 8'h06);
    chk("R4 data", ev[b+4], 8'h5A);
    chk("R4 stop", ev[b+5], EV_STOP);
    cyc(WAIT_CYC - 10);
    chk("R5 busy during wait", int'(busy), 1);
    req(8'h77, 1'b0);
    adj(1'b0, 8'h10);
    wait_idle(40, used);
    chk("R5 wait ends", int'(busy), 0);
    chk("R5 request ignored while busy", ev_n, b + 6);
    chk("R8 R5 addr after single", int'(addr), 16'h0007);
    chk("R11 scl high time", int'(hi_len), 2 * QTR * CLK_PERIOD);
  endtask

  task automatic t_bank;
    int b;
    int used;
    adj(1'b1, 8'h09);
    chk("R10 addr to bank1", int'(addr), 16'hFFFE);
    b = ev_n;
    req(8'hC3, 1'b0);
    wait_idle(3000, used);
    chk("R3 ctrl bank1", ev[b+1], 8'hAE);
    chk("R4 bank1 addr hi", ev[b+2], 8'hFF);
    chk("R4 bank1 addr lo", ev[b+3], 8'hFE);
    chk("R4 bank1 stop", ev[b+5], EV_STOP);
    chk("R8 addr after bank1", int'(addr), 16'hFFFF);
  endtask

  task automatic t_page;
    int b = ev_n;
    int used;
    req(8'h11, 1'b1);
    wait_idle(3000, used);
    chk("R6 first page frame len", ev_n, b + 5);
    chk("R6 start", ev[b], EV_START);
    chk("R6 ctrl", ev[b+1], 8'hAE);
    chk("R6 addr hi", ev[b+2], 8'hFF);
    chk("R6 addr lo", ev[b+3], 8'hFF);
    chk("R6 data1", ev[b+4], 8'h11);
    chk("R6 scl held low", int'(scl_w), 0);
    chk("R8 wrap to zero", int'(addr), 16'h0000);
    req(8'h22, 1'b0);
    wait_idle(3000, used);
    chk("R6 data only", ev_n, b + 6);
    chk("R6 data2", ev[b+5], 8'h22);
    chk("R8 addr after data2", int'(addr), 16'h0001);
    @(negedge clk); page_end = 1'b1;
    @(negedge clk); page_end = 1'b0;
    wait_ev(b + 7);
    chk("R7 stop on page end", ev[b+6], EV_STOP);
    chk("R7 wait after page stop", int'(busy), 1);
    wait_idle(3000, used);
    chk("R7 wait length", int'(used > WAIT_CYC - 10), 1);
    @(negedge clk); page_end = 1'b1;
    @(negedge clk); page_end = 1'b0;
    cyc(50);
    chk("R7 idle page end ignored", ev_n, b + 7);
    chk("R7 idle page end busy", int'(busy), 0);
  endtask

  task automatic t_nack;
    int b = ev_n;
    int e0 = err_cnt;
    int used;
    nack_en = 1'b1;
    req(8'h99, 1'b0);
    wait_ev(b + 3);
    wait_idle(3000, used);
    nack_en = 1'b0;
    chk("R9 frame aborted", ev_n, b + 3);
    chk("R9 ctrl sent", ev[b+1], 8'hA6);
    chk("R9 stop", ev[b+2], EV_STOP);
    chk("R9 one pulse", err_cnt - e0, 1);
    chk("R9 no wait", int'(used < 10), 1);
    chk("R9 addr held", int'(addr), 16'h0001);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_adjust();
    t_single();
    t_bank();
    t_page();
    t_nack();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule